// File: doc/BRIEF.md
# I2C Master Byte Engine

This block performs one I2C master operation per command: a start condition (optionally followed by an address byte), a data byte write, a data byte read, or a stop condition. It drives the open-drain SCL and SDA pads through active-high pull-down enables and reads the resolved line levels back. A free-running divider paced by a 16-bit prescale value sets the bit timing. Register decode and interrupt handling sit outside this block. The controller issues a command as single-cycle strobes, waits for the `done` pulse, and then reads the result flags.

A bit cell is divided into five equal phases. SCL is held low for phases 0, 1 and 4 and released for phases 2 and 3. SDA is changed only at the start of phase 0, and the line is sampled at the end of phase 2, which is the midpoint of the high time. The engine does not give up the bus after a byte. It keeps SCL low until the next command, so a start issued at that point produces a repeated start. For multi-master use, the engine detects when it has lost arbitration and then releases the bus. A separate line monitor tracks whether the bus is busy, whichever master generated the start and stop conditions.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, both pad enables are low and `tip`, `done`, `busy`, `nack` and `arb_lost` are all 0.
- R2: If `cmd_start` and `cmd_write` are strobed together, the engine makes SDA fall while SCL is high. It then sends `tx_byte` MSB first and latches the ninth-bit level into `nack`.
- R3: A `cmd_write` strobe on its own sends `tx_byte` MSB first. `nack` becomes 1 if SDA was high in the ninth bit (the slave did not acknowledge) and 0 if SDA was low.
- R4: A `cmd_read` strobe clocks in 8 bits MSB first into `rx_byte`. In the ninth bit the engine releases SDA (NACK) when `cmd_ack` was 1 and pulls SDA low (ACK) when `cmd_ack` was 0.
- R5: `tip` is high from the clock cycle after a command is accepted. Every command ends with a one-cycle `done` pulse, and `tip` falls in that same cycle.
- R6: One SCL period during a byte lasts exactly 5*(`prescale`+1) clock cycles.
- R7: While a byte is being written or read, the engine changes its SDA enable only while its SCL enable is active.
- R8: If the engine releases SDA to send a 1 but samples SDA low while SCL is high, it sets `arb_lost`, releases both lines and pulses `done`. `arb_lost` is cleared when the next command is accepted.
- R9: A `cmd_stop` strobe makes SDA rise while SCL is high. Both lines are released and `busy` is 0 by the time `done` pulses.
- R10: `busy` becomes 1 when a start condition appears on the lines and 0 when a stop condition appears, whichever master caused it.
- R11: A start issued while the engine still holds SCL low produces a repeated start. A fresh start condition is seen on the lines and `busy` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | 16 | Phase length minus one, in clock cycles |
| cmd_start | input | 1 | Strobe: start condition (send address with cmd_write) |
| cmd_write | input | 1 | Strobe: send tx_byte |
| cmd_read | input | 1 | Strobe: receive a byte |
| cmd_stop | input | 1 | Strobe: stop condition |
| cmd_ack | input | 1 | For reads: 1 sends NACK in the ninth bit, 0 sends ACK |
| tx_byte | input | 8 | Byte to send |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_byte | output | 8 | Received byte |
| done | output | 1 | One-cycle command completion pulse |
| nack | output | 1 | 1 if the last written byte was not acknowledged |
| arb_lost | output | 1 | Arbitration was lost during the last command |
| tip | output | 1 | Command in progress |
| busy | output | 1 | Bus held between a start and a stop condition |

## Verification
Arbitration loss and normal byte completion can both end a command, and both meet in the single `done` pulse. The bench provokes this overlap by having the slave model pull SDA low only under the final data bit of the byte 0x01. The abort then falls in the last sampling slot, just before the byte would have finished normally. The bench judges the result by requiring exactly one `done`, `arb_lost` set, `nack` unchanged and both enables released. It then checks that the released lines produce a stop condition that clears `busy`.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } eng_state_e;

  localparam int PHASES    = 5;
  localparam int SAMPLE_AT = 2;
endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = run && (cnt == prescale);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == prescale) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_eng_bus_mon.sv
module i2c_eng_bus_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy
);
  logic scl_q, sda_q;
  logic saw_start, saw_stop;

  assign saw_start = scl_q && scl_i && sda_q && !sda_i;
  assign saw_stop  = scl_q && scl_i && !sda_q && sda_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (saw_start) begin
        busy <= 1'b1;
      end else if (saw_stop) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic          cmd_read,
  input  logic          cmd_stop,
  input  logic          cmd_ack,
  input  logic [DW-1:0] tx_byte,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [DW-1:0] rx_byte,
  output logic          done,
  output logic          nack,
  output logic          arb_lost,
  output logic          tip
);
  localparam int PH_W  = $clog2(PHASES);
  localparam int BIT_W = $clog2(DW + 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(SAMPLE_AT);
  localparam logic [PH_W-1:0]  PH_HIGH   = PH_W'(2);
  localparam logic [PH_W-1:0]  PH_EDGE   = PH_W'(3);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(DW);

  eng_state_e      st, st_n;
  logic [PH_W-1:0] ph, ph_n;
  logic [BIT_W-1:0] bidx, bidx_n;
  logic [DW-1:0]   sreg, sreg_n, rxr, rxr_n;
  logic            own, own_n, pend, pend_n, rd, rd_n, ackc, ackc_n;
  logic            tip_n, done_n, nack_n, arb_n, abort;
  logic            scl_n, sda_n, any_cmd;

  assign any_cmd = cmd_start | cmd_write | cmd_read | cmd_stop;
  assign rx_byte = rxr;

  always_comb begin
    st_n   = st;
    ph_n   = ph;
    bidx_n = bidx;
    sreg_n = sreg;
    rxr_n  = rxr;
    own_n  = own;
    pend_n = pend;
    rd_n   = rd;
    ackc_n = ackc;
    tip_n  = tip;
    done_n = 1'b0;
    nack_n = nack;
    arb_n  = arb_lost;
    abort  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (any_cmd) begin
          tip_n  = 1'b1;
          arb_n  = 1'b0;
          ph_n   = '0;
          bidx_n = '0;
          sreg_n = tx_byte;
          ackc_n = cmd_ack;
          rd_n   = cmd_read & ~cmd_write;
          pend_n = cmd_write;
          if (cmd_start) begin
            st_n = ST_START;
          end else if (cmd_stop) begin
            st_n = ST_STOP;
          end else begin
            st_n = ST_BITS;
          end
        end
      end
      ST_START: begin
        if (tick) begin
          if (ph == PH_LAST) begin
            ph_n  = '0;
            own_n = 1'b1;
            if (pend) begin
              st_n   = ST_BITS;
              bidx_n = '0;
              rd_n   = 1'b0;
            end else begin
              st_n   = ST_IDLE;
              tip_n  = 1'b0;
              done_n = 1'b1;
            end
          end else begin
            ph_n = ph + 1'b1;
          end
        end
      end
      ST_BITS: begin
        if (tick) begin
          if (ph == PH_SAMPLE) begin
            if (bidx < ACK_SLOT) begin
              if (rd) begin
                rxr_n = {rxr[DW-2:0], sda_i};
              end else if (sreg[DW-1] && scl_i && !sda_i) begin
                abort = 1'b1;
              end
            end else if (!rd) begin
              nack_n = sda_i;
            end
          end
          if (abort) begin
            st_n   = ST_IDLE;
            ph_n   = '0;
            own_n  = 1'b0;
            arb_n  = 1'b1;
            tip_n  = 1'b0;
            done_n = 1'b1;
          end else if (ph == PH_LAST) begin
            ph_n = '0;
            if (bidx == ACK_SLOT) begin
              st_n   = ST_IDLE;
              tip_n  = 1'b0;
              done_n = 1'b1;
            end else begin
              bidx_n = bidx + 1'b1;
              sreg_n = {sreg[DW-2:0], 1'b0};
            end
          end else begin
            ph_n = ph + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (ph == PH_LAST) begin
            ph_n   = '0;
            own_n  = 1'b0;
            st_n   = ST_IDLE;
            tip_n  = 1'b0;
            done_n = 1'b1;
          end else begin
            ph_n = ph + 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // pad enables follow the state being entered, so they change on the same edge
  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    unique case (st_n)
      ST_IDLE: scl_n = own_n;
      ST_START: begin
        if (ph_n == '0) begin
          scl_n = own_n;
        end else if (ph_n == PH_EDGE) begin
          sda_n = 1'b1;
        end else if (ph_n == PH_LAST) begin
          scl_n = 1'b1;
          sda_n = 1'b1;
        end
      end
      ST_BITS: begin
        scl_n = (ph_n < PH_HIGH) || (ph_n == PH_LAST);
        if (bidx_n < ACK_SLOT) begin
          sda_n = !rd_n && !sreg_n[DW-1];
        end else begin
          sda_n = rd_n && !ackc_n;
        end
      end
      ST_STOP: begin
        scl_n = (ph_n == '0);
        sda_n = (ph_n < PH_EDGE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= '0;
      bidx     <= '0;
      sreg     <= '0;
      rxr      <= '0;
      own      <= 1'b0;
      pend     <= 1'b0;
      rd       <= 1'b0;
      ackc     <= 1'b0;
      tip      <= 1'b0;
      done     <= 1'b0;
      nack     <= 1'b0;
      arb_lost <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      st       <= st_n;
      ph       <= ph_n;
      bidx     <= bidx_n;
      sreg     <= sreg_n;
      rxr      <= rxr_n;
      own      <= own_n;
      pend     <= pend_n;
      rd       <= rd_n;
      ackc     <= ackc_n;
      tip      <= tip_n;
      done     <= done_n;
      nack     <= nack_n;
      arb_lost <= arb_n;
      scl_oe   <= scl_n;
      sda_oe   <= sda_n;
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic              cmd_read,
  input  logic              cmd_stop,
  input  logic              cmd_ack,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              nack,
  output logic              arb_lost,
  output logic              tip,
  output logic              busy
);
  logic tick;

  i2c_eng_tick #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (tip),
    .prescale (prescale),
    .tick     (tick)
  );

  i2c_eng_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd_start (cmd_start),
    .cmd_write (cmd_write),
    .cmd_read  (cmd_read),
    .cmd_stop  (cmd_stop),
    .cmd_ack   (cmd_ack),
    .tx_byte   (tx_byte),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rx_byte   (rx_byte),
    .done      (done),
    .nack      (nack),
    .arb_lost  (arb_lost),
    .tip       (tip)
  );

  i2c_eng_bus_mon u_mon (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .busy  (busy)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic tip,
  input logic arb_lost,
  input logic scl_oe,
  input logic sda_oe
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  done_tip_chk: assert property (@(posedge clk) disable iff (rst) done |-> !tip);
  // R5
  tip_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(tip) |-> done);
  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && arb_lost) |-> (!scl_oe && !sda_oe));
  // R8
  arb_done_chk: assert property (@(posedge clk) disable iff (rst) $rose(arb_lost) |-> done);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .tip      (tip),
  .arb_lost (arb_lost),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe)
);

// File: tb/i2c_byte_engine_bench.sv
`timescale 1ns/1ps
module i2c_byte_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [15:0] prescale = '0;
  logic cmd_start = 0, cmd_write = 0, cmd_read = 0, cmd_stop = 0, cmd_ack = 0;
  logic [7:0] tx_byte = '0;
  logic scl_oe, sda_oe, done, nack, arb_lost, tip, busy;
  logic [7:0] rx_byte;
  logic scl_line, sda_line;

  // stimulus-side pulls (initial-driven) and slave pull (model-driven)
  logic x_scl = 0, x_sda = 0, s_sda = 0;
  assign scl_line = ~scl_oe & ~x_scl;
  assign sda_line = ~sda_oe & ~s_sda & ~x_sda;

  i2c_byte_engine u_i2c_byte_engine (
    .clk(clk), .rst(rst), .prescale(prescale),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .tx_byte(tx_byte),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .done(done), .nack(nack), .arb_lost(arb_lost),
    .tip(tip), .busy(busy)
  );

  // slave configuration: 0 idle, 1 receive, 2 transmit, 3 contend
  logic arm = 0;
  int cfg_mode = 0, cfg_fight = 0;
  logic cfg_ack = 0, chk_en = 0;
  logic [7:0] cfg_rdata = '0;

  int cyc = 0, fall_cnt = 0, rise_cnt = 0, last_rise = -1;
  int start_cnt = 0, stop_cnt = 0, per_min = 0, per_max = 0, viol = 0;
  logic [7:0] cap = '0;
  logic m_ack = 0, p_scl = 1, p_sda = 1, p_soe = 0, p_coe = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (chk_en && (sda_oe != p_soe) && !scl_oe && !p_coe) viol = viol + 1;
    if (p_scl && scl_line && !p_sda && sda_line) stop_cnt = stop_cnt + 1;
    if (arm) begin
      rise_cnt = 0; fall_cnt = 0; cap = '0; last_rise = -1;
      per_min = 1 << 30; per_max = 0;
      s_sda = (cfg_mode == 2) ? ~cfg_rdata[7] : (cfg_mode == 3 && cfg_fight == 0);
    end else begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        start_cnt = start_cnt + 1;
        rise_cnt = 0; fall_cnt = -1; cap = '0; last_rise = -1;
      end
      if (scl_line && !p_scl) begin
        if (last_rise >= 0 && rise_cnt >= 1 && rise_cnt <= 7) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (rise_cnt < 8) cap = {cap[6:0], sda_line};
        else if (rise_cnt == 8) m_ack = sda_line;
        rise_cnt = rise_cnt + 1;
      end
      if (!scl_line && p_scl) begin
        fall_cnt = fall_cnt + 1;
        if (cfg_mode == 1) begin
          if (fall_cnt == 8) s_sda = cfg_ack;
          else if (fall_cnt == 9) s_sda = 1'b0;
        end else if (cfg_mode == 2) begin
          if (fall_cnt >= 1 && fall_cnt < 8) s_sda = ~cfg_rdata[7 - fall_cnt];
          else s_sda = 1'b0;
        end else if (cfg_mode == 3) begin
          if (fall_cnt == cfg_fight) s_sda = 1'b1;
        end
      end
    end
    p_scl = scl_line; p_sda = sda_line; p_soe = sda_oe; p_coe = scl_oe;
  end

  int checks = 0, errors = 0;
  logic busy_dropped = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic s, input logic w, input logic r, input logic p,
                       input logic a, input logic [7:0] val, input int mode,
                       input logic sack, input int fight);
    int n;
    step();
    cfg_mode = mode; cfg_ack = sack; cfg_rdata = val; cfg_fight = fight; arm = 1;
    cmd_start = s; cmd_write = w; cmd_read = r; cmd_stop = p; cmd_ack = a; tx_byte = val;
    step();
    arm = 0; cmd_start = 0; cmd_write = 0; cmd_read = 0; cmd_stop = 0; cmd_ack = 0;
    @(negedge clk);
    if (!tip) check("R5 tip after accept", tip, 1);
    busy_dropped = 0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      if (!busy) busy_dropped = 1;
      n = n + 1;
    end
    if (!done) check("R5 done timeout", 0, 1);
    if (tip) check("R5 tip at done", tip, 0);
  endtask

  task automatic arm_idle();
    step(); cfg_mode = 0; arm = 1;
    step(); arm = 0;
    repeat (3) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks = checks + 1; errors = errors + 1;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st0;
    repeat (4) step();
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {scl_oe, sda_oe, tip, done, busy, nack, arb_lost}, 0);

    // R2: start plus address from idle
    st0 = start_cnt;
    issue(1, 1, 0, 0, 0, 8'hA4, 1, 1, 0);
    check("R2 start seen", start_cnt - st0, 1);
    check("R2 address bits", cap, 8'hA4);
    check("R2 ack captured", nack, 0);
    check("R10 busy after start", busy, 1);
    @(negedge clk);
    check("R5 done one cycle", done, 0);

    // R3, R7: every byte value, slave acknowledge pattern varies
    chk_en = 1;
    for (int b = 0; b < 256; b++) begin
      issue(0, 1, 0, 0, 0, 8'(b), 1, (b % 3) != 0, 0);
      check("R3 write bits", cap, b);
      check("R3 nack flag", nack, ((b % 3) != 0) ? 0 : 1);
    end
    // R4: every byte value, ack control alternating
    for (int b = 0; b < 256; b++) begin
      issue(0, 0, 1, 0, b[1], 8'(b), 2, 0, 0);
      check("R4 read bits", rx_byte, b);
      check("R4 master ack bit", m_ack, b[1]);
    end
    chk_en = 0;
    check("R7 sda change with scl high", viol, 0);

    // R11: repeated start while SCL is held
    st0 = start_cnt;
    issue(1, 1, 0, 0, 0, 8'h5A, 1, 1, 0);
    check("R11 repeated start seen", start_cnt - st0, 1);
    check("R11 busy held", busy_dropped, 0);
    check("R11 address bits", cap, 8'h5A);

    // R8: contention under the last data bit, coincides with byte end
    issue(0, 1, 0, 0, 0, 8'h01, 3, 0, 7);
    check("R8 arb lost on last bit", arb_lost, 1);
    check("R8 lines released", {scl_oe, sda_oe}, 0);
    check("R8 nack untouched", nack, 0);
    arm_idle();
    check("R10 stop by release clears busy", busy, 0);

    // R8: contention on first bit
    issue(1, 1, 0, 0, 0, 8'h10, 1, 1, 0);
    issue(0, 1, 0, 0, 0, 8'h80, 3, 0, 0);
    check("R8 arb lost on first bit", arb_lost, 1);
    arm_idle();
    issue(1, 1, 0, 0, 0, 8'h22, 1, 1, 0);
    check("R8 arb cleared by next command", arb_lost, 0);

    // R9: stop
    st0 = stop_cnt;
    issue(0, 0, 0, 1, 0, 8'h00, 0, 0, 0);
    check("R9 stop seen", stop_cnt - st0, 1);
    check("R9 busy low at done", busy, 0);
    check("R9 lines released", {scl_oe, sda_oe}, 0);

    // R10: start and stop generated by another master
    step(); x_sda = 1;
    repeat (3) step();
    check("R10 foreign start", busy, 1);
    x_sda = 0;
    repeat (3) step();
    check("R10 foreign stop", busy, 0);

    // R6: bit period across prescale values
    for (int p = 0; p < 6; p++) begin
      prescale = 16'(p);
      issue(1, 1, 0, 0, 0, 8'hC3, 1, 1, 0);
      check("R6 min period", per_min, 5 * (p + 1));
      check("R6 max period", per_max, 5 * (p + 1));
      issue(0, 0, 0, 1, 0, 8'h00, 0, 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule